// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a behavioural model of a synchronous burst static RAM, 64 bits wide, with a small parameterised depth. Two active-low address strobes start an access: one comes from the processor and one from the chipset. Later beats of a burst walk the two low address bits in linear or interleaved order, as selected by a static strap, each time the advance input is low. Writes can be qualified per byte. A global write input forces all eight bytes to be written.

A second static strap picks the read path. In flow-through mode the read word comes straight from the array. In pipelined mode it passes through an output register, and the write data and byte lines are taken one clock after the address (late write). The output-enable input gates the data-bus driver asynchronously. The driver is exposed as a data value plus a pad enable. A sleep input freezes the block: stored data and the burst position are kept, and all other inputs are ignored.

Top module: `burst_sram`

## Requirements
- R1: While rstN is low, and in the cycle after it is released, no read datum is valid, so dataOutEn is 0 even with oeN low.
- R2: adspN low loads addr and starts a read even when gwN or bweN is low. It takes priority over adscN, and no byte is written in that cycle.
- R3: With adspN high and adscN low, addr is loaded. The access is a write when gwN is 0 or bweN is 0, and a read otherwise.
- R4: advN low with no strobe steps a two-bit beat count. The access address keeps the upper bits of the loaded address. Its two low bits are start+count mod 4 when orderSel=0 (linear, 01→10→11→00), and start XOR count when orderSel=1 (interleaved, 11→10→01→00).
- R5: With both strobes high and advN high, the block rewrites the current address if gwN or bweN is 0 (suspended write). Otherwise it performs no access and no read result follows.
- R6: gwN=0 writes all eight bytes, whatever bweN and bwN are. In pipelined mode gwN is taken in the address cycle.
- R7: With gwN=1 and bweN=0, byte i (dataIn[8i+7:8i]) is written only when bwN[i]=0.
- R8: With pipeSel=1, the write data and bwN are taken at the clock edge after the one that took the address. The bwN values present in the address cycle have no effect.
- R9: With pipeSel=0, the write data and bwN are taken at the same edge as the address.
- R10: A read whose address is taken at edge k shows its datum in the cycle after edge k when pipeSel=0, and in the cycle after edge k+1 when pipeSel=1. Burst beats then follow one per cycle.
- R11: dataOutEn is high only when oeN is low, a read datum is valid, no pipelined write is waiting for its data, and sleep is low. It follows oeN without a clock edge.
- R12: While sleep is high, the array and the burst position are unchanged and all other inputs are ignored. Reads and writes already in progress are dropped. After release, advN continues from the held burst position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input except oeN is sampled on its rising edge |
| rstN | input | 1 | Synchronous active-low reset of control state |
| adspN | input | 1 | Processor address strobe, active low, read-only start |
| adscN | input | 1 | Chipset address strobe, active low, read or write start |
| advN | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gwN | input | 1 | Global write, active low, all bytes |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | DATA_W/8 | Per-byte write lines, active low |
| pipeSel | input | 1 | Static strap: 0 flow-through, 1 pipelined |
| orderSel | input | 1 | Static strap: 0 linear, 1 interleaved burst order |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| dataIn | input | DATA_W | Write data from the bus |
| dataOut | output | DATA_W | Read data toward the bus |
| dataOutEn | output | 1 | Bus driver enable (high = drive, low = high-impedance) |

## Verification
On every cycle, the assertions check four things. A processor-strobe cycle in flow-through mode never writes. A pipelined read sets its second-stage valid flag two edges after the strobe. A pipelined write command is always followed by an array commit. The burst position is reloaded on a strobe and frozen during sleep. Only the bench scenarios can show the data contents. These include the linear and interleaved beat orders read back from the array, partial and global byte merges, the late capture of byte lines in pipelined mode, the suspended write leaving its neighbour intact, sleep leaving contents and burst position unchanged, and the output enable reacting between clock edges.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic memWr;     // commit a masked write at this edge
    logic outLoad;   // capture the addressed word into the output register
    logic showData;  // a read datum is valid on dataOut this cycle
    logic usePipe;   // dataOut comes from the output register
  } ctrl_strb_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

endpackage

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hold,
  input  logic          load,
  input  logic          adv,
  input  logic          orderSel,
  input  logic [AW-1:0] loadAddr,
  output logic [AW-1:0] accAddr
);

  localparam int CW = 2;

  logic [AW-1:0] baseQ, baseD;
  logic [CW-1:0] offQ, offD;
  logic [CW-1:0] lowBits;

  function automatic logic [CW-1:0] mixLow(input logic [CW-1:0] start,
                                           input logic [CW-1:0] cnt,
                                           input logic interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction

  always_comb begin
    baseD = load ? loadAddr : baseQ;
    if (load)     offD = '0;
    else if (adv) offD = offQ + CW'(1);
    else          offD = offQ;
  end

  assign lowBits = mixLow(baseD[CW-1:0], offD, orderSel);

  generate
    if (AW > CW) begin : g_wide
      assign accAddr = {baseD[AW-1:CW], lowBits};
    end else begin : g_narrow
      assign accAddr = lowBits;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
    end else if (!hold) begin
      baseQ <= baseD;
      offQ  <= offD;
    end
  end

  // R4
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (load && !hold) |=> (offQ == '0 && baseQ == $past(loadAddr)));

  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> ($stable(baseQ) && $stable(offQ)));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic [AW-1:0]    addr,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             pipeSel,
  input  logic             orderSel,
  input  logic             sleep,
  output ctrl_strb_t       strb,
  output logic [AW-1:0]    wrAddr,
  output logic [LANES-1:0] wrMask,
  output logic [AW-1:0]    rdAddr
);

  logic          loadP, loadC, wrReq, stepAdv;
  acc_e          acc;
  logic [AW-1:0] accAddr;

  logic          rdV1, rdV2;
  logic [AW-1:0] rdAddrQ;
  logic          pendWr, pendGw;
  logic [AW-1:0] pendAddr;

  assign loadP   = !adspN;
  assign loadC   = adspN && !adscN;
  assign wrReq   = !gwN || !bweN;
  assign stepAdv = !advN && !loadP && !loadC;

  // access decode: processor strobe always reads
  always_comb begin
    if (loadP)                acc = ACC_READ;
    else if (wrReq)           acc = ACC_WRITE;
    else if (loadC || !advN)  acc = ACC_READ;
    else                      acc = ACC_IDLE;
  end

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (sleep),
    .load     (loadP || loadC),
    .adv      (stepAdv),
    .orderSel (orderSel),
    .loadAddr (addr),
    .accAddr  (accAddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdV1     <= 1'b0;
      rdV2     <= 1'b0;
      rdAddrQ  <= '0;
      pendWr   <= 1'b0;
      pendGw   <= 1'b0;
      pendAddr <= '0;
    end else if (sleep) begin
      rdV1   <= 1'b0;
      rdV2   <= 1'b0;
      pendWr <= 1'b0;
    end else begin
      rdV1     <= (acc == ACC_READ);
      rdV2     <= rdV1;
      rdAddrQ  <= accAddr;
      pendWr   <= pipeSel && (acc == ACC_WRITE);
      pendGw   <= !gwN;
      pendAddr <= accAddr;
    end
  end

  always_comb begin
    strb   = '0;
    wrAddr = accAddr;
    wrMask = '0;
    if (!sleep) begin
      if (pipeSel) begin
        strb.memWr = pendWr;
        wrAddr     = pendAddr;
        wrMask     = pendGw ? {LANES{1'b1}} : ~bwN;
      end else begin
        strb.memWr = (acc == ACC_WRITE);
        wrMask     = !gwN ? {LANES{1'b1}} : ~bwN;
      end
    end
    strb.outLoad  = !sleep && rdV1;
    strb.usePipe  = pipeSel;
    strb.showData = (pipeSel ? rdV2 : rdV1) && !pendWr && !sleep;
  end

  assign rdAddr = rdAddrQ;

  // R2
  adsp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !sleep && !pipeSel) |-> !strb.memWr);

  // R10
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rstN || sleep)
    (!adspN && pipeSel) |-> ##2 rdV2);

  // R8
  late_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeSel && !sleep && acc == ACC_WRITE) |=> (sleep || strb.memWr));

endmodule

// File: rtl/sram_dp.sv
`timescale 1ns/1ps
module sram_dp
  import burst_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DATA_W = 64,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  ctrl_strb_t        strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [LANES-1:0]  wrMask,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH  = 1 << AW;
  localparam int BYTE_W = DATA_W / LANES;

  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] outQ;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
        if (strb.memWr && wrMask[g])
          cells[wrAddr] <= dataIn[g*BYTE_W +: BYTE_W];
      end
      assign readWord[g*BYTE_W +: BYTE_W] = cells[rdAddr];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.outLoad) outQ <= readWord;
  end

  assign dataOut   = strb.usePipe ? outQ : readWord;
  assign dataOutEn = !oeN && strb.showData;

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                adspN,
  input  logic                adscN,
  input  logic                advN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                gwN,
  input  logic                bweN,
  input  logic [DATA_W/8-1:0] bwN,
  input  logic                pipeSel,
  input  logic                orderSel,
  input  logic                oeN,
  input  logic                sleep,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOutEn
);

  localparam int LANES = DATA_W / 8;

  ctrl_strb_t        strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0]  wrMask;

  sram_ctrl #(.AW(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .adspN    (adspN),
    .adscN    (adscN),
    .advN     (advN),
    .addr     (addr),
    .gwN      (gwN),
    .bweN     (bweN),
    .bwN      (bwN),
    .pipeSel  (pipeSel),
    .orderSel (orderSel),
    .sleep    (sleep),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrMask   (wrMask),
    .rdAddr   (rdAddr)
  );

  sram_dp #(.AW(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .wrMask    (wrMask),
    .rdAddr    (rdAddr),
    .dataIn    (dataIn),
    .oeN       (oeN),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic        gwN = 1'b1, bweN = 1'b1;
  logic [7:0]  bwN = 8'hFF;
  logic        pipeSel = 1'b1, orderSel = 1'b0;
  logic        oeN = 1'b0, sleep = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] dataOut;
  logic        dataOutEn;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .DATA_W(64)) uut (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .addr(addr), .gwN(gwN), .bweN(bweN), .bwN(bwN), .pipeSel(pipeSel),
    .orderSel(orderSel), .oeN(oeN), .sleep(sleep), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  localparam logic [63:0] D0 = 64'hA0A1A2A3A4A5A6A7;
  localparam logic [63:0] D1 = 64'hB0B1B2B3B4B5B6B7;
  localparam logic [63:0] D2 = 64'hC0C1C2C3C4C5C6C7;
  localparam logic [63:0] D3 = 64'hD0D1D2D3D4D5D6D7;
  localparam logic [63:0] D4 = 64'h1122334455667788;
  localparam logic [63:0] D5 = 64'h99AABBCCDDEEFF00;
  localparam logic [63:0] E0 = 64'h0123456789ABCDEF;
  localparam logic [63:0] E1 = 64'h1032547698BADCFE;
  localparam logic [63:0] E2 = 64'h2301674589ABEFCD;
  localparam logic [63:0] E3 = 64'h3210765498BAFEDC;
  localparam logic [63:0] E4 = 64'h5A5A5A5A5A5A5A5A;
  localparam logic [63:0] E5 = 64'h0F0F0F0F0F0F0F0F;
  localparam logic [63:0] G0 = 64'h1111111111111111;
  localparam logic [63:0] G1 = 64'h2222222222222222;
  localparam logic [63:0] G2 = 64'h3333333333333333;
  localparam logic [63:0] G3 = 64'h4444444444444444;

  typedef struct packed {
    logic        aP, aC, av, g, b;
    logic [7:0]  bw;
    logic [5:0]  a;
    logic [63:0] d;
    logic        oe;
    logic        expEn;
    logic [63:0] expD;
    logic [3:0]  req;
  } vec_t;

  // pipelined, linear order; each row applied in one cycle, output checked in that cycle
  localparam vec_t VEC [25] = '{
    '{1,0,1,1,0,8'hFF,6'h09,64'h0,1,0,64'h0,4'd3},                 // R3 chipset write start at 0x09
    '{1,1,0,1,0,8'h00,6'h00,D0,1,0,64'h0,4'd8},                    // R8 data for 0x09
    '{1,1,0,1,0,8'h00,6'h00,D1,1,0,64'h0,4'd4},                    // R4 0x0A
    '{1,1,0,1,0,8'h00,6'h00,D2,1,0,64'h0,4'd4},                    // R4 0x0B
    '{1,1,1,1,1,8'h00,6'h00,D3,1,0,64'h0,4'd5},                    // R5 idle, last beat 0x08
    '{0,1,1,1,1,8'hFF,6'h09,64'h0,0,0,64'h0,4'd2},                 // R2 read start
    '{1,1,0,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd10},                // R10 not yet
    '{1,1,0,1,1,8'hFF,6'h00,64'h0,0,1,D0,4'd10},                   // R10 first datum
    '{1,1,0,1,1,8'hFF,6'h00,64'h0,0,1,D1,4'd4},                    // R4
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,1,D2,4'd4},                    // R4
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,1,D3,4'd4},                    // R4 wrap 11->00
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd5},                 // R5 idle gives nothing
    '{1,0,1,1,0,8'h00,6'h09,64'h0,1,0,64'h0,4'd8},                 // R8 byte lines here ignored
    '{1,1,1,1,1,8'hF0,6'h00,D4,1,0,64'h0,4'd7},                    // R7 low four bytes
    '{1,0,1,0,1,8'hFF,6'h0A,64'h0,1,0,64'h0,4'd6},                 // R6 global write at 0x0A
    '{1,1,1,1,1,8'hFF,6'h00,D5,1,0,64'h0,4'd6},                    // R6 data, lines all high
    '{0,1,1,1,1,8'hFF,6'h09,64'h0,0,0,64'h0,4'd2},                 // R2
    '{1,1,0,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd10},                // R10
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,1,64'hA0A1A2A355667788,4'd7},  // R7 merged word
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,1,D5,4'd6},                    // R6
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd5},                 // R5
    '{0,0,1,0,0,8'h00,6'h0A,64'hDEADDEADDEADDEAD,0,0,64'h0,4'd2},  // R2 both strobes, write ignored
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd10},                // R10
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,1,D5,4'd2},                    // R2 0x0A unchanged
    '{1,1,1,1,1,8'hFF,6'h00,64'h0,0,0,64'h0,4'd5}                  // R5
  };

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic expEn, input logic [63:0] expD);
    total++;
    if (dataOutEn !== expEn || (expEn && dataOut !== expD)) begin
      bad++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               tag, dataOutEn, dataOut, expEn, expD);
    end
  endtask

  task automatic apply(input logic aP, input logic aC, input logic av,
                       input logic g, input logic b, input logic [7:0] bw,
                       input logic [5:0] a, input logic [63:0] d,
                       input logic oe, input logic sl);
    @(negedge clk);
    adspN = aP; adscN = aC; advN = av; gwN = g; bweN = b;
    bwN = bw; addr = a; dataIn = d; oeN = oe; sleep = sl;
    #1;
  endtask

  task automatic doReset(input logic pSel, input logic oSel);
    @(negedge clk);
    rstN = 1'b0; pipeSel = pSel; orderSel = oSel;
    adspN = 1; adscN = 1; advN = 1; gwN = 1; bweN = 1; bwN = 8'hFF;
    oeN = 1'b0; sleep = 1'b0;
    #1;
    chk("R1 in reset", 1'b0, 64'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 after reset", 1'b0, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    // pipelined, linear
    doReset(1'b1, 1'b0);
    for (int i = 0; i < 25; i++) begin
      apply(VEC[i].aP, VEC[i].aC, VEC[i].av, VEC[i].g, VEC[i].b, VEC[i].bw,
            VEC[i].a, VEC[i].d, VEC[i].oe, 1'b0);
      chk($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].expEn, VEC[i].expD);
    end

    // flow-through, interleaved
    doReset(1'b0, 1'b1);
    // R9 R4: burst write from 0x13 goes 0x13,0x12,0x11,0x10
    apply(1,0,1,1,0,8'h00,6'h13,E0,1,0); chk("R9 write start", 0, 0);
    apply(1,1,0,1,0,8'h00,6'h00,E1,1,0);
    apply(1,1,0,1,0,8'h00,6'h00,E2,1,0);
    apply(1,1,0,1,0,8'h00,6'h00,E3,1,0);
    apply(0,1,1,1,1,8'hFF,6'h13,64'h0,0,0); chk("R10 flow idle before read", 0, 0);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R10 flow first datum", 1, E0);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R4 interleaved 0x12", 1, E1);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R4 interleaved 0x11", 1, E2);
    apply(1,1,1,1,1,8'hFF,6'h00,64'h0,0,0); chk("R4 interleaved 0x10", 1, E3);
    apply(1,1,1,1,1,8'hFF,6'h00,64'h0,0,0); chk("R5 idle after burst", 0, 0);
    // R7 R6 R3
    apply(1,0,1,1,0,8'h7F,6'h13,E4,1,0);
    apply(1,0,1,0,1,8'hFF,6'h12,E5,1,0);
    apply(1,0,1,1,1,8'hFF,6'h11,64'h0,0,0); chk("R3 chipset write gives no datum", 0, 0);
    apply(0,1,1,1,1,8'hFF,6'h13,64'h0,0,0); chk("R3 chipset read of 0x11", 1, E2);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R7 only byte 7 written", 1, {E4[63:56], E0[55:0]});
    apply(1,1,1,1,1,8'hFF,6'h00,64'h0,0,0); chk("R6 global write full word", 1, E5);
    // R5 suspended write
    apply(1,0,1,1,0,8'h00,6'h20,G0,1,0);
    apply(1,1,0,1,0,8'h00,6'h00,G1,1,0);
    apply(1,0,1,1,0,8'h00,6'h20,G2,1,0);
    apply(1,1,1,1,0,8'h00,6'h00,G3,1,0);
    apply(0,1,1,1,1,8'hFF,6'h20,64'h0,0,0);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R5 suspend rewrote 0x20", 1, G3);
    apply(1,1,1,1,1,8'hFF,6'h00,64'h0,0,0); chk("R5 neighbour 0x21 kept", 1, G1);
    // R12 sleep
    apply(0,1,1,1,1,8'hFF,6'h10,64'h0,0,0); chk("R12 before sleep", 0, 0);
    apply(1,0,1,0,0,8'h00,6'h10,64'hBADBADBADBADBAD0,0,1); chk("R12 bus off in sleep", 0, 0);
    apply(0,0,0,0,0,8'h00,6'h3F,64'hBADBADBADBADBAD1,0,1); chk("R12 bus off in sleep 2", 0, 0);
    apply(1,1,0,1,1,8'hFF,6'h00,64'h0,0,0); chk("R12 read dropped by sleep", 0, 0);
    apply(0,1,1,1,1,8'hFF,6'h10,64'h0,0,0); chk("R12 burst resumed at 0x11", 1, E2);
    apply(1,1,1,1,1,8'hFF,6'h00,64'h0,0,0); chk("R12 0x10 kept", 1, E3);
    // R11 asynchronous output enable, mid-cycle
    oeN = 1'b1; #0.5; chk("R11 oe off without clock", 0, 0);
    oeN = 1'b0; #0.5; chk("R11 oe on without clock", 1, E3);

    finishRun();
  end

endmodule